// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when an external temperature converter is told to start. In continuous operation it issues a start request once per period, chosen from four fixed conversion rates, and sits idle between conversions. A sleep control stops the periodic requests. While asleep, software can ask for one conversion on demand through a single-shot control whose status reads back as set until that conversion has finished. A conversion is also launched straight after reset, without waiting for a period to pass.

The converter is reached only through a start pulse and a done strobe that carries the result. The block latches that result into the temperature value it presents. The time base is a prescaled tick. It is built from two parameters: clock cycles per tick, and ticks per 125 ms unit. A bench can therefore shrink every period while keeping the ratios between the rates.

Top module: `tconv_sched`

## Requirements
- R1: The rate select sets the time between periodic start pulses in 125 ms units: code 2'b00 gives 32 units (4 s), 2'b01 gives 8 units (1 s), 2'b10 gives 2 units (250 ms, the recommended default) and 2'b11 gives 1 unit (125 ms). One unit is TICKS_UNIT ticks and one tick is CLK_PER_TICK clock cycles, so the gap is units*TICKS_UNIT*CLK_PER_TICK cycles.
- R2: During reset, conv_start, oneshot_busy and temp_value are all 0. On the first clock edge after reset is released, conv_start is asserted. temp_value stays 0 until the first done strobe.
- R3: conv_start is a one-cycle pulse and is never issued while a conversion is outstanding. The period restarts at every start. If the period expires while a conversion is outstanding, the start follows on the clock edge after the done strobe.
- R4: While sleep_en is 1, no periodic start is issued. When sleep_en returns to 0, periodic starts resume, and if the period has already elapsed the next start comes at once.
- R5: In sleep, a oneshot_wr pulse sets oneshot_busy on the next edge. The start pulse follows one edge later if the converter is idle. oneshot_busy returns to 0 on the edge of that conversion's done strobe, and no further starts follow while sleep_en stays 1.
- R6: A oneshot_wr pulse in the same cycle in which sleep_en first becomes 1 is accepted, and that conversion runs.
- R7: temp_value changes only on a clock edge where conv_done is 1 and a conversion is outstanding. On that edge it takes conv_data.
- R8: A oneshot_wr pulse while sleep_en is 0 has no effect: oneshot_busy stays 0 and no extra start is issued.
- R9: A conv_done strobe while no conversion is outstanding is ignored, and temp_value keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Conversion rate code (see R1) |
| sleep_en | input | 1 | 1 stops periodic conversions |
| oneshot_wr | input | 1 | One-cycle pulse: software wrote 1 to the single-shot control |
| oneshot_busy | output | 1 | Single-shot status, 1 from acceptance until its conversion ends |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| conv_data | input | TEMP_W | Conversion result, valid with conv_done |
| temp_value | output | TEMP_W | Latched result of the last completed conversion |

## Verification
The bench measures the exact gap between start pulses at each rate code. A scheduler whose prescaler keeps running across a start would show a gap that jitters by up to one tick, and a late or early period compare would be off by a cycle. It holds the done strobe back far past a short period, to catch a design that restarts an active converter or never resumes after the late done. It also covers a single-shot write issued together with entering sleep, a single-shot write while awake, and a stray done with no conversion outstanding. A design that got these wrong would lose the combined write, set a status bit that never clears, or overwrite the temperature with garbage.

// File: rtl/tconv_pkg.sv
package tconv_pkg;

   typedef enum logic [1:0] {
      RATE_QUARTER_HZ = 2'b00,
      RATE_ONE_HZ     = 2'b01,
      RATE_FOUR_HZ    = 2'b10,
      RATE_EIGHT_HZ   = 2'b11
   } rate_e;

   // Longest period, counted in 125 ms units
   localparam int unsigned UNITS_MAX = 32;

   function automatic int unsigned rate_units(input logic [1:0] code);
      int unsigned u;
      case (rate_e'(code))
         RATE_QUARTER_HZ: u = 32;
         RATE_ONE_HZ:     u = 8;
         RATE_FOUR_HZ:    u = 2;
         default:         u = 1;
      endcase
      return u;
   endfunction

endpackage

// File: rtl/tconv_tick.sv
module tconv_tick #(
   parameter int CLK_PER_TICK = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   if (CLK_PER_TICK < 1) begin : g_bad_div
      $error("tconv_tick: CLK_PER_TICK must be at least 1");
   end

   if (CLK_PER_TICK == 1) begin : g_direct
      logic unused_clr;
      assign unused_clr = clr;
      assign tick = 1'b1;
   end else begin : g_div
      localparam int PW = $clog2(CLK_PER_TICK);
      localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             pre_q <= '0;
         else if (clr)           pre_q <= '0;
         else if (pre_q == LAST) pre_q <= '0;
         else                    pre_q <= pre_q + 1'b1;
      end

      assign tick = (pre_q == LAST);

      // Divided tick never lasts two cycles in a row
      assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end

endmodule

// File: rtl/tconv_period.sv
module tconv_period
   import tconv_pkg::*;
#(
   parameter int TICKS_UNIT = 125
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] rate,
   input  logic       tick,
   input  logic       restart,
   output logic       hit
);

   if (TICKS_UNIT < 1) begin : g_bad_unit
      $error("tconv_period: TICKS_UNIT must be at least 1");
   end

   localparam int CNT_MAX = UNITS_MAX * TICKS_UNIT;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] period;
   logic [CNT_W:0]   cnt_inc;

   assign period  = CNT_W'(rate_units(rate) * TICKS_UNIT);
   assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

   // Saturating tick count since the last launch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (restart)              cnt_q <= '0;
      else if (tick && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
   end

   // Expired already, or expires with this tick
   assign hit = (cnt_q >= period) || (tick && (cnt_inc >= {1'b0, period}));

   // A saturated count keeps the request alive until it is served
   assert_hit_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !restart && $stable(rate)) |=> hit);

endmodule

// File: rtl/tconv_oneshot.sv
module tconv_oneshot (
   input  logic clk,
   input  logic rst_n,
   input  logic ss_wr,
   input  logic sleep_cfg,
   input  logic launch,
   input  logic done_ev,
   output logic pend,
   output logic own
);

   logic pend_q;
   logic own_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pend_q <= 1'b0;
      else if (done_ev && own_q)  pend_q <= 1'b0;
      else if (ss_wr && sleep_cfg) pend_q <= 1'b1;
   end

   // Marks the outstanding conversion as the one-shot one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       own_q <= 1'b0;
      else if (launch)  own_q <= pend_q;
      else if (done_ev) own_q <= 1'b0;
   end

   assign pend = pend_q;
   assign own  = own_q;

   assert_ss_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !sleep_cfg) |=> !pend_q);

   assert_ss_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !(own_q && done_ev)) |=> pend_q);

endmodule

// File: rtl/tconv_sched.sv
module tconv_sched
   import tconv_pkg::*;
#(
   parameter int CLK_PER_TICK = 1000,
   parameter int TICKS_UNIT   = 125,
   parameter int TEMP_W       = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        rate_sel,
   input  logic              sleep_en,
   input  logic              oneshot_wr,
   output logic              oneshot_busy,
   output logic              conv_start,
   input  logic              conv_done,
   input  logic [TEMP_W-1:0] conv_data,
   output logic [TEMP_W-1:0] temp_value
);

   if (TEMP_W < 2) begin : g_bad_width
      $error("tconv_sched: TEMP_W must be at least 2");
   end

   logic              boot_q;
   logic              busy_q;
   logic              start_q;
   logic [TEMP_W-1:0] temp_q;
   logic              tick;
   logic              hit;
   logic              go;
   logic              done_ev;
   logic              ss_pend;
   logic              ss_own;

   assign done_ev = conv_done && busy_q;
   assign go = !busy_q && (boot_q || ss_pend || (!sleep_en && hit));

   tconv_tick #(.CLK_PER_TICK(CLK_PER_TICK)) i_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (go),
      .tick  (tick)
   );

   tconv_period #(.TICKS_UNIT(TICKS_UNIT)) i_period (
      .clk     (clk),
      .rst_n   (rst_n),
      .rate    (rate_sel),
      .tick    (tick),
      .restart (go),
      .hit     (hit)
   );

   tconv_oneshot i_oneshot (
      .clk       (clk),
      .rst_n     (rst_n),
      .ss_wr     (oneshot_wr),
      .sleep_cfg (sleep_en),
      .launch    (go),
      .done_ev   (done_ev),
      .pend      (ss_pend),
      .own       (ss_own)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_q  <= 1'b1;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= go;
         if (go) begin
            boot_q <= 1'b0;
            busy_q <= 1'b1;
         end else if (done_ev) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       temp_q <= '0;
      else if (done_ev) temp_q <= conv_data;
   end

   assign conv_start   = start_q;
   assign oneshot_busy = ss_pend;
   assign temp_value   = temp_q;

   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);

   assert_no_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !start_q);

   assert_temp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(conv_done && busy_q) |=> $stable(temp_q));

   assert_sleep_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_en && !ss_pend && !boot_q) |=> !start_q);

endmodule

// File: tb/test_tconv_sched.sv
module test_tconv_sched;

   localparam int CLK_PERIOD = 10;
   localparam int CPT  = 2;
   localparam int TU   = 3;
   localparam int TW   = 12;
   localparam int NVEC = 4;
   // stimulus: rate code; expected: cycles between starts
   localparam logic [1:0] VEC_RATE [NVEC] = '{2'b10, 2'b11, 2'b01, 2'b00};
   localparam int         VEC_GAP  [NVEC] = '{2*TU*CPT, 1*TU*CPT, 8*TU*CPT, 32*TU*CPT};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    rate_sel = 2'b10;
   logic          sleep_en = 1'b0;
   logic          oneshot_wr = 1'b0;
   logic          oneshot_busy;
   logic          conv_start;
   logic          conv_done;
   logic [TW-1:0] conv_data;
   logic [TW-1:0] temp_value;

   logic          auto_en = 1'b1;
   logic          auto_done = 1'b0;
   logic [TW-1:0] auto_data = 12'h190;
   logic [TW-1:0] last_sent = '0;
   int            dly_cnt = 0;
   logic          man_done = 1'b0;
   logic [TW-1:0] man_data = '0;

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;

   assign conv_done = auto_done | man_done;
   assign conv_data = man_done ? man_data : auto_data;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tconv_sched #(.CLK_PER_TICK(CPT), .TICKS_UNIT(TU), .TEMP_W(TW)) i_tconv_sched (
      .clk          (clk),
      .rst_n        (rst_n),
      .rate_sel     (rate_sel),
      .sleep_en     (sleep_en),
      .oneshot_wr   (oneshot_wr),
      .oneshot_busy (oneshot_busy),
      .conv_start   (conv_start),
      .conv_done    (conv_done),
      .conv_data    (conv_data),
      .temp_value   (temp_value)
   );

   // Converter model: done three cycles after each start
   always @(negedge clk) begin
      if (auto_done) auto_done = 1'b0;
      if (dly_cnt > 0) begin
         dly_cnt = dly_cnt - 1;
         if (dly_cnt == 0) begin
            auto_data = auto_data + 12'h013;
            last_sent = auto_data;
            auto_done = 1'b1;
         end
      end
      if (conv_start && auto_en && dly_cnt == 0) dly_cnt = 3;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic wait_start(input int limit, output int at, output bit seen);
      seen = 1'b0;
      at = -1;
      for (int k = 0; k < limit && !seen; k++) begin
         @(negedge clk);
         if (conv_start) begin
            seen = 1'b1;
            at = cyc;
         end
      end
   endtask

   task automatic count_starts(input int n, output int c);
      c = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (conv_start) c++;
      end
   endtask

   task automatic pulse_ss();
      oneshot_wr = 1'b1;
      @(negedge clk);
      oneshot_wr = 1'b0;
   endtask

   task automatic man_strobe(input logic [TW-1:0] d);
      man_data = d;
      man_done = 1'b1;
      @(negedge clk);
      man_done = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      int  t0, t1, t2, c;
      bit  s;

      // R2: reset state
      repeat (4) @(negedge clk);
      chk(conv_start == 1'b0, "R2 start in reset", int'(conv_start), 0);
      chk(oneshot_busy == 1'b0, "R2 status in reset", int'(oneshot_busy), 0);
      chk(temp_value == '0, "R2 temp in reset", int'(temp_value), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(conv_start == 1'b1, "R2 boot start", int'(conv_start), 1);
      chk(temp_value == '0, "R2 temp before first done", int'(temp_value), 0);

      // R1 / R7: rate table
      for (int i = 0; i < NVEC; i++) begin
         rate_sel = VEC_RATE[i];
         wait_start(400, t0, s);
         wait_start(400, t1, s);
         chk(temp_value == last_sent, "R7 temp at start", int'(temp_value), int'(last_sent));
         wait_start(400, t2, s);
         chk(s && (t2 - t1) == VEC_GAP[i], "R1 period gap", t2 - t1, VEC_GAP[i]);
         repeat (6) @(negedge clk);
         chk(temp_value == last_sent, "R7 temp after done", int'(temp_value), int'(last_sent));
      end

      // R4: sleep blocks periodic starts
      rate_sel = 2'b11;
      sleep_en = 1'b1;
      count_starts(300, c);
      chk(c == 0, "R4 no start asleep", c, 0);

      // R5: single shot in sleep
      pulse_ss();
      chk(oneshot_busy == 1'b1, "R5 status set", int'(oneshot_busy), 1);
      chk(conv_start == 1'b0, "R5 start not yet", int'(conv_start), 0);
      @(negedge clk);
      chk(conv_start == 1'b1, "R5 start issued", int'(conv_start), 1);
      chk(oneshot_busy == 1'b1, "R5 status while running", int'(oneshot_busy), 1);
      repeat (6) @(negedge clk);
      chk(oneshot_busy == 1'b0, "R5 status cleared", int'(oneshot_busy), 0);
      chk(temp_value == last_sent, "R5 result latched", int'(temp_value), int'(last_sent));
      count_starts(300, c);
      chk(c == 0, "R5 stays asleep", c, 0);

      // R4: wake with elapsed period
      sleep_en = 1'b0;
      wait_start(4, t0, s);
      chk(s, "R4 resume immediate", int'(s), 1);
      repeat (6) @(negedge clk);

      // R6: single shot written with entry to sleep
      sleep_en = 1'b1;
      pulse_ss();
      chk(oneshot_busy == 1'b1, "R6 status set", int'(oneshot_busy), 1);
      wait_start(4, t0, s);
      chk(s, "R6 conversion runs", int'(s), 1);
      repeat (6) @(negedge clk);
      chk(oneshot_busy == 1'b0, "R6 status cleared", int'(oneshot_busy), 0);
      count_starts(100, c);
      chk(c == 0, "R6 stays asleep", c, 0);

      // R8: single shot while awake is ignored
      sleep_en = 1'b0;
      wait_start(4, t0, s);
      repeat (6) @(negedge clk);
      rate_sel = 2'b00;
      pulse_ss();
      chk(oneshot_busy == 1'b0, "R8 status stays 0", int'(oneshot_busy), 0);
      count_starts(50, c);
      chk(c == 0, "R8 no extra start", c, 0);

      // R3: period expires while converter is busy
      rate_sel = 2'b11;
      auto_en = 1'b0;
      wait_start(400, t0, s);
      count_starts(60, c);
      chk(c == 0, "R3 no start while busy", c, 0);
      man_strobe(12'h5A5);
      chk(temp_value == 12'h5A5, "R7 late result", int'(temp_value), 'h5A5);
      wait_start(4, t1, s);
      chk(s, "R3 start after late done", int'(s), 1);
      man_strobe(12'h3C3);
      sleep_en = 1'b1;
      repeat (3) @(negedge clk);
      chk(temp_value == 12'h3C3, "R7 second result", int'(temp_value), 'h3C3);

      // R9: done with nothing outstanding
      man_strobe(12'h0F0);
      repeat (2) @(negedge clk);
      chk(temp_value == 12'h3C3, "R9 stray done ignored", int'(temp_value), 'h3C3);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule